// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block puts the command interface of a parallel NOR flash with the Intel-style command set in front of a small on-chip storage array. It sits on a simple synchronous bus with a word address, write data, byte enables, and read and write strobes. Bus writes are taken as command bytes. Their low byte is decoded against a command register, a two-bit write phase and a status register. Depending on the latched command, a read returns array data, the status byte, identification codes or a query table.

The array is built as one byte-wide device per byte lane. Status, identification and query responses therefore appear once in every lane of the read word. Program and erase take effect in the clock edge that accepts them, and the block never reports a busy period. A `ro_mode` input makes the array read-only. In that mode, program and erase attempts set sticky error bits in the status register and leave the stored data untouched. The `seq_err` output pulses for one cycle when a command sequence is rejected.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the status register is 0x00, `seq_err` and `rd_valid` are low, the block is in read-array mode, and every array word reads as all ones.
- R2: In the idle phase, write byte 0x10 or 0x40 arms one program. The next bus write stores its data at its word address, but only in the lanes whose `wr_be` bit is set. It also sets status bit 7 (ready) and returns to the idle phase.
- R3: Write byte 0x20 immediately sets to all ones every word of the BLK_WORDS-aligned block that holds the address, and sets ready. A second write of 0xD0 returns to idle with the command kept. A second write of 0xFF returns to read-array mode. Any other second byte pulses `seq_err` and returns to read-array mode.
- R4: While `ro_mode` is high, program and erase leave the array unchanged. A refused erase sets status bit 5 (0x20) and a refused program sets status bit 4 (0x10). Ready is still set in both cases.
- R5: Write byte 0x50 clears the whole status register and selects read-array mode. Bytes 0x00, 0xF0 and 0xFF select read-array mode without touching status.
- R6: Bytes 0x70 and 0x90 only latch the command. The phase stays idle, so the next write is decoded as a new command.
- R7: While the latched command is 0x10, 0x20, 0x40, 0x60, 0x70 or 0xE8, a read returns the status byte in every byte lane.
- R8: Byte 0x60 waits for a second write. Values 0xD0 and 0x01 return to idle with ready set. Any other value selects read-array mode without pulsing `seq_err`.
- R9: Byte 0xE8 sets ready and starts a buffered write. The next write gives a count N, taken from its low 8 bits. The next N+1 writes each store a data word (ready is set; an error bit is set if read-only). A final 0xD0 returns to idle with ready set. Any other final value selects read-array mode without `seq_err`, and the data already stored stays.
- R10: With command 0x90 latched, a read returns MFR_CODE at word address 0, DEV_CODE at address 1 and 0x00 elsewhere, in every lane.
- R11: With command 0x98 latched, a read returns a query byte in every lane, indexed by the low 8 bits of the word address: 0x10..0x12 give 0x51, 0x52, 0x59; 0x13 gives 0x01; 0x27 gives log2(WORDS); 0x2C gives 0x01; 0x2D gives WORDS/BLK_WORDS-1; unlisted indices give 0x00. Only 0xFF leaves query mode; other writes are ignored.
- R12: An unrecognised idle-phase command pulses `seq_err` for one cycle, selects read-array mode and leaves status unchanged.
- R13: `rd_data` and `rd_valid` are registered: a read strobe sampled at one edge gives valid data after that edge, and `rd_valid` is high only in the cycle after a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Word address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Write data; low byte is the command byte |
| wr_be | input | LANES | Byte-lane enables for array data writes |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DW | Registered read response |
| rd_valid | output | 1 | High in the cycle after a read strobe |
| ro_mode | input | 1 | Treat the array as read-only |
| seq_err | output | 1 | One-cycle pulse on a rejected sequence |

## Verification
The bench keeps a full model of the array and compares every word after each program, erase and buffered-write pattern, including partial byte enables. A wrong lane mask or a wrong block-boundary computation would corrupt neighbouring words or miss erased ones. It goes after the differences between second-cycle outcomes: an erase with a bad confirm must pulse `seq_err`, while a bad lock byte or bad buffered-write confirm must return to read-array mode silently. A design that mixed these up would either flag legal aborts or leave status reads active. It also checks that 0x70/0x90 do not advance the phase, that the buffered-write count writes exactly N+1 words, and that read-only attempts set the right sticky bit without altering data.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  localparam int LANE_W = 8;

  localparam logic [7:0] C_RST0    = 8'h00;
  localparam logic [7:0] C_PROG_A  = 8'h10;
  localparam logic [7:0] C_ERASE   = 8'h20;
  localparam logic [7:0] C_PROG_B  = 8'h40;
  localparam logic [7:0] C_CLRST   = 8'h50;
  localparam logic [7:0] C_LOCK    = 8'h60;
  localparam logic [7:0] C_RDST    = 8'h70;
  localparam logic [7:0] C_RDID    = 8'h90;
  localparam logic [7:0] C_QUERY   = 8'h98;
  localparam logic [7:0] C_BUFWR   = 8'hE8;
  localparam logic [7:0] C_EXIT_A  = 8'hF0;
  localparam logic [7:0] C_READARR = 8'hFF;
  localparam logic [7:0] C_CONFIRM = 8'hD0;
  localparam logic [7:0] C_LOCKALT = 8'h01;

  localparam int ST_READY    = 7;
  localparam int ST_ERASE_ER = 5;
  localparam int ST_PROG_ER  = 4;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ARG     = 2'd1,
    PH_DATA    = 2'd2,
    PH_CONFIRM = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_STATUS = 2'd1,
    RD_IDENT  = 2'd2,
    RD_QUERY  = 2'd3
  } rdsrc_t;

  function automatic rdsrc_t src_of(input logic [7:0] c);
    case (c)
      C_PROG_A, C_ERASE, C_PROG_B, C_CLRST,
      C_LOCK, C_RDST, C_BUFWR: return RD_STATUS;
      C_RDID:                  return RD_IDENT;
      C_QUERY:                 return RD_QUERY;
      default:                 return RD_ARRAY;
    endcase
  endfunction

endpackage

// File: rtl/nfc_ctrl.sv
module nfc_ctrl
  import nfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] op,
  input  logic       ro_mode,
  output logic       mem_we,
  output logic       erase_en,
  output logic [7:0] cmd_q,
  output phase_t     phase_q,
  output logic [7:0] cnt_q,
  output logic [7:0] status_q,
  output logic       seq_err
);

  logic [7:0] cmd_d, cnt_d, st_d;
  phase_t     ph_d;
  logic       rej, back, prog, ers;

  always_comb begin
    cmd_d = cmd_q;
    ph_d  = phase_q;
    cnt_d = cnt_q;
    st_d  = status_q;
    rej   = 1'b0;
    back  = 1'b0;
    prog  = 1'b0;
    ers   = 1'b0;
    if (wr_en) begin
      case (phase_q)
        PH_IDLE: begin
          case (op)
            C_RST0, C_EXIT_A, C_READARR: back = 1'b1;
            C_PROG_A, C_PROG_B: begin
              cmd_d = op;
              ph_d  = PH_ARG;
            end
            C_ERASE: begin
              ers = 1'b1;
              if (ro_mode) st_d[ST_ERASE_ER] = 1'b1;
              st_d[ST_READY] = 1'b1;
              cmd_d = op;
              ph_d  = PH_ARG;
            end
            C_CLRST: begin
              st_d = '0;
              back = 1'b1;
            end
            C_LOCK, C_QUERY: begin
              cmd_d = op;
              ph_d  = PH_ARG;
            end
            C_RDST, C_RDID: cmd_d = op;
            C_BUFWR: begin
              st_d[ST_READY] = 1'b1;
              cmd_d = op;
              ph_d  = PH_ARG;
            end
            default: rej = 1'b1;
          endcase
        end
        PH_ARG: begin
          case (cmd_q)
            C_PROG_A, C_PROG_B: begin
              prog = 1'b1;
              if (ro_mode) st_d[ST_PROG_ER] = 1'b1;
              st_d[ST_READY] = 1'b1;
              ph_d = PH_IDLE;
            end
            C_ERASE: begin
              if (op == C_CONFIRM) begin
                ph_d = PH_IDLE;
                st_d[ST_READY] = 1'b1;
              end else if (op == C_READARR) begin
                back = 1'b1;
              end else begin
                rej = 1'b1;
              end
            end
            C_BUFWR: begin
              cnt_d = op;
              ph_d  = PH_DATA;
            end
            C_LOCK: begin
              if (op == C_CONFIRM || op == C_LOCKALT) begin
                ph_d = PH_IDLE;
                st_d[ST_READY] = 1'b1;
              end else begin
                back = 1'b1;
              end
            end
            C_QUERY: begin
              if (op == C_READARR) back = 1'b1;
            end
            default: rej = 1'b1;
          endcase
        end
        PH_DATA: begin
          if (cmd_q == C_BUFWR) begin
            prog = 1'b1;
            if (ro_mode) st_d[ST_PROG_ER] = 1'b1;
            st_d[ST_READY] = 1'b1;
            if (cnt_q == 8'd0) ph_d = PH_CONFIRM;
            cnt_d = cnt_q - 8'd1;
          end else begin
            rej = 1'b1;
          end
        end
        PH_CONFIRM: begin
          if (cmd_q == C_BUFWR) begin
            if (op == C_CONFIRM) begin
              ph_d = PH_IDLE;
              st_d[ST_READY] = 1'b1;
            end else begin
              back = 1'b1;
            end
          end else begin
            rej = 1'b1;
          end
        end
        default: rej = 1'b1;
      endcase
      if (rej || back) begin
        cmd_d = C_RST0;
        ph_d  = PH_IDLE;
      end
    end
  end

  assign mem_we   = prog & ~ro_mode;
  assign erase_en = ers & ~ro_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= C_RST0;
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      status_q <= '0;
      seq_err  <= 1'b0;
    end else begin
      cmd_q    <= cmd_d;
      phase_q  <= ph_d;
      cnt_q    <= cnt_d;
      status_q <= st_d;
      seq_err  <= rej;
    end
  end

endmodule

// File: rtl/nfc_array.sv
module nfc_array #(
  parameter  int WORDS     = 64,
  parameter  int LANES     = 2,
  parameter  int BLK_WORDS = 16,
  localparam int AW        = $clog2(WORDS),
  localparam int BW        = $clog2(BLK_WORDS),
  localparam int DW        = LANES * 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] wbe,
  input  logic             erase,
  output logic [DW-1:0]    rword
);

  logic [AW-BW-1:0] blk_sel;
  assign blk_sel = addr[AW-1:BW];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] lane_mem [WORDS];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int w = 0; w < WORDS; w++) lane_mem[w] <= 8'hFF;
      end else begin
        for (int w = 0; w < WORDS; w++) begin
          if (erase && ((w / BLK_WORDS) == int'(blk_sel))) lane_mem[w] <= 8'hFF;
        end
        if (we && wbe[l]) lane_mem[addr] <= wdata[l*8 +: 8];
      end
    end

    assign rword[l*8 +: 8] = lane_mem[addr];
  end

endmodule

// File: rtl/nfc_rdmux.sv
module nfc_rdmux
  import nfc_pkg::*;
#(
  parameter  int         WORDS     = 64,
  parameter  int         LANES     = 2,
  parameter  int         BLK_WORDS = 16,
  parameter  logic [7:0] MFR_CODE  = 8'h89,
  parameter  logic [7:0] DEV_CODE  = 8'h18,
  localparam int         AW        = $clog2(WORDS),
  localparam int         DW        = LANES * 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    cmd,
  input  logic [7:0]    status,
  input  logic [DW-1:0] aword,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  localparam logic [7:0]  SZ_LOG  = 8'($clog2(WORDS));
  localparam logic [15:0] NBLK_M1 = 16'(WORDS / BLK_WORDS - 1);
  localparam logic [23:0] BLK_B   = 24'(BLK_WORDS);

  function automatic logic [7:0] query_byte(input logic [7:0] i);
    case (i)
      8'h10:   return 8'h51;
      8'h11:   return 8'h52;
      8'h12:   return 8'h59;
      8'h13:   return 8'h01;
      8'h27:   return SZ_LOG;
      8'h2C:   return 8'h01;
      8'h2D:   return NBLK_M1[7:0];
      8'h2E:   return NBLK_M1[15:8];
      8'h2F:   return BLK_B[15:8];
      8'h30:   return BLK_B[23:16];
      default: return 8'h00;
    endcase
  endfunction

  logic [7:0]    idx;
  logic [7:0]    lane_byte;
  logic [DW-1:0] nxt;
  rdsrc_t        src;

  assign idx = 8'(addr);
  assign src = src_of(cmd);

  always_comb begin
    case (src)
      RD_STATUS: lane_byte = status;
      RD_IDENT:  lane_byte = (idx == 8'd0) ? MFR_CODE :
                             (idx == 8'd1) ? DEV_CODE : 8'h00;
      RD_QUERY:  lane_byte = query_byte(idx);
      default:   lane_byte = 8'h00;
    endcase
    nxt = (src == RD_ARRAY) ? aword : {LANES{lane_byte}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= nxt;
    end
  end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nfc_pkg::*;
#(
  parameter  int         WORDS     = 64,
  parameter  int         LANES     = 2,
  parameter  int         BLK_WORDS = 16,
  parameter  logic [7:0] MFR_CODE  = 8'h89,
  parameter  logic [7:0] DEV_CODE  = 8'h18,
  localparam int         AW        = $clog2(WORDS),
  localparam int         DW        = LANES * 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    bus_addr,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic [LANES-1:0] wr_be,
  input  logic             rd_en,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  input  logic             ro_mode,
  output logic             seq_err
);

  logic [7:0]    cmd_q, cnt_q, status_q;
  phase_t        phase_q;
  logic          mem_we, erase_en;
  logic [DW-1:0] aword;

  nfc_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .op       (wr_data[7:0]),
    .ro_mode  (ro_mode),
    .mem_we   (mem_we),
    .erase_en (erase_en),
    .cmd_q    (cmd_q),
    .phase_q  (phase_q),
    .cnt_q    (cnt_q),
    .status_q (status_q),
    .seq_err  (seq_err)
  );

  nfc_array #(
    .WORDS     (WORDS),
    .LANES     (LANES),
    .BLK_WORDS (BLK_WORDS)
  ) u_array (
    .clk   (clk),
    .rst   (rst),
    .we    (mem_we),
    .addr  (bus_addr),
    .wdata (wr_data),
    .wbe   (wr_be),
    .erase (erase_en),
    .rword (aword)
  );

  nfc_rdmux #(
    .WORDS     (WORDS),
    .LANES     (LANES),
    .BLK_WORDS (BLK_WORDS),
    .MFR_CODE  (MFR_CODE),
    .DEV_CODE  (DEV_CODE)
  ) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .addr     (bus_addr),
    .cmd      (cmd_q),
    .status   (status_q),
    .aword    (aword),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk
  import nfc_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] op,
  input logic       rd_en,
  input logic       rd_valid,
  input logic       seq_err,
  input logic       ro_mode,
  input logic [7:0] st,
  input logic [7:0] cmd,
  input logic [7:0] cnt,
  input logic [1:0] ph
);

  assert_err_after_write_R12: assert property (@(posedge clk) disable iff (rst)
    seq_err |-> $past(wr_en));

  assert_valid_follows_R13: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));

  assert_valid_due_R13: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en) |-> rd_valid);

  assert_ready_clear_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(st[ST_READY]) |-> $past(wr_en && op == C_CLRST && ph == 2'd0));

  assert_erase_err_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(st[ST_ERASE_ER]) |-> $past(ro_mode));

  assert_prog_err_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(st[ST_PROG_ER]) |-> $past(ro_mode));

  assert_count_done_R9: assert property (@(posedge clk) disable iff (rst)
    (ph == 2'd3 && $past(ph) == 2'd2) |-> ($past(cnt) == 8'd0));

  assert_latch_only_R6: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && ph == 2'd0 && (op == C_RDST || op == C_RDID))
      |-> (ph == 2'd0 && cmd == $past(op)));

endmodule

bind nor_cmd_seq nor_cmd_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .op       (wr_data[7:0]),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .seq_err  (seq_err),
  .ro_mode  (ro_mode),
  .st       (status_q),
  .cmd      (cmd_q),
  .cnt      (cnt_q),
  .ph       (phase_q)
);

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;

  localparam int WORDS = 64;
  localparam int BLK   = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [1:0]  wr_be = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        ro_mode = 1'b0;
  logic        seq_err;

  int tests = 0;
  int fails = 0;
  logic [15:0] ref_mem [WORDS];
  logic [15:0] got;

  always #10 clk = ~clk;

  nor_cmd_seq u_dut (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .wr_be    (wr_be),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .ro_mode  (ro_mode),
    .seq_err  (seq_err)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    bus_addr = a; wr_data = d; wr_be = be; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
    if (rd_valid !== 1'b1) begin
      tests++; fails++;
      $display("FAIL R13 rd_valid actual=%b expected=1", rd_valid);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic sweep(input string tag);
    wr(6'd0, 16'h00FF, 2'b11);
    for (int w = 0; w < WORDS; w++) rd_chk(tag, 6'(w), ref_mem[w]);
  endtask

  task automatic ref_store(input logic [5:0] a, input logic [15:0] d, input logic [1:0] be);
    if (!ro_mode) begin
      if (be[0]) ref_mem[a][7:0]  = d[7:0];
      if (be[1]) ref_mem[a][15:8] = d[15:8];
    end
  endtask

  task automatic ref_erase(input logic [5:0] a);
    if (!ro_mode)
      for (int w = 0; w < WORDS; w++)
        if (w / BLK == int'(a) / BLK) ref_mem[w] = 16'hFFFF;
  endtask

  task automatic prog(input logic [5:0] a, input logic [15:0] d, input logic [1:0] be);
    wr(a, 16'h0040, 2'b11);
    wr(a, d, be);
    ref_store(a, d, be);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int w = 0; w < WORDS; w++) ref_mem[w] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 seq_err", 16'(seq_err), 16'h0);
    chk("R13 rd_valid idle", 16'(rd_valid), 16'h0);
    sweep("R1 erased array");
    wr(6'd0, 16'h0070, 2'b11);
    rd_chk("R1 status zero", 6'd0, 16'h0000);

    // R2 program with byte-lane patterns
    for (int w = 0; w < WORDS; w++) begin
      logic [1:0] be;
      be = (w % 4 == 1) ? 2'b01 : (w % 4 == 2) ? 2'b10 : 2'b11;
      prog(6'(w), 16'(w * 16'h0123 + 16'h1111), be);
    end
    rd_chk("R7 status after program", 6'd3, 16'h8080);
    sweep("R2 program");

    // R3 erase then confirm
    wr(6'd23, 16'h0020, 2'b11); ref_erase(6'd23);
    wr(6'd0, 16'h00D0, 2'b11);
    rd_chk("R3 status after erase", 6'd5, 16'h8080);
    sweep("R3 erase block 1");
    wr(6'd50, 16'h0020, 2'b11); ref_erase(6'd50);
    wr(6'd50, 16'h00FF, 2'b11);
    rd_chk("R3 erase then read-array", 6'd50, 16'hFFFF);
    wr(6'd2, 16'h0020, 2'b11); ref_erase(6'd2);
    wr(6'd2, 16'h0055, 2'b11);
    chk("R3 bad confirm seq_err", 16'(seq_err), 16'h1);
    @(negedge clk);
    chk("R12 seq_err one cycle", 16'(seq_err), 16'h0);
    rd_chk("R3 read-array after reject", 6'd7, 16'hFFFF);
    sweep("R3 after erases");

    // R5 clear status and reset commands
    wr(6'd0, 16'h0050, 2'b11);
    wr(6'd0, 16'h0070, 2'b11);
    rd_chk("R5 status cleared", 6'd0, 16'h0000);
    prog(6'd9, 16'hC3A5, 2'b11);
    wr(6'd0, 16'h0000, 2'b11);
    rd_chk("R5 0x00 read-array", 6'd9, 16'hC3A5);
    wr(6'd0, 16'h0070, 2'b11);
    wr(6'd0, 16'h00F0, 2'b11);
    rd_chk("R5 0xF0 read-array", 6'd9, 16'hC3A5);

    // R6 latch-only commands
    wr(6'd0, 16'h0090, 2'b11);
    prog(6'd12, 16'hBEEF, 2'b11);
    wr(6'd0, 16'h0070, 2'b11);
    prog(6'd13, 16'h7E57, 2'b11);
    wr(6'd0, 16'h00FF, 2'b11);
    rd_chk("R6 program after 0x90", 6'd12, 16'hBEEF);
    rd_chk("R6 program after 0x70", 6'd13, 16'h7E57);

    // R8 lock sequences
    wr(6'd0, 16'h0050, 2'b11);
    wr(6'd0, 16'h0060, 2'b11);
    wr(6'd0, 16'h0001, 2'b11);
    rd_chk("R8 lock 0x01 ready", 6'd0, 16'h8080);
    wr(6'd0, 16'h0050, 2'b11);
    wr(6'd0, 16'h0060, 2'b11);
    wr(6'd0, 16'h00D0, 2'b11);
    rd_chk("R8 lock 0xD0 ready", 6'd0, 16'h8080);
    wr(6'd0, 16'h0060, 2'b11);
    wr(6'd0, 16'h0077, 2'b11);
    chk("R8 no seq_err", 16'(seq_err), 16'h0);
    rd_chk("R8 bad byte read-array", 6'd12, 16'hBEEF);

    // R9 buffered write, count from low byte
    wr(6'd0, 16'h0050, 2'b11);
    wr(6'd40, 16'h00E8, 2'b11);
    wr(6'd40, 16'h0103, 2'b11);
    for (int k = 0; k < 4; k++) begin
      wr(6'(40 + k), 16'(16'hA000 + k * 16'h0111), 2'b11);
      ref_store(6'(40 + k), 16'(16'hA000 + k * 16'h0111), 2'b11);
    end
    wr(6'd40, 16'h00D0, 2'b11);
    chk("R9 confirm no seq_err", 16'(seq_err), 16'h0);
    rd_chk("R9 status after confirm", 6'd40, 16'h8080);
    sweep("R9 buffered data");
    wr(6'd44, 16'h00E8, 2'b11);
    wr(6'd44, 16'h0200, 2'b11);
    wr(6'd44, 16'h5AA5, 2'b11); ref_store(6'd44, 16'h5AA5, 2'b11);
    wr(6'd44, 16'h0012, 2'b11);
    chk("R9 bad confirm no seq_err", 16'(seq_err), 16'h0);
    rd_chk("R9 abort keeps data", 6'd44, 16'h5AA5);
    rd_chk("R9 single word only", 6'd45, ref_mem[45]);

    // R10 identification
    wr(6'd0, 16'h0090, 2'b11);
    rd_chk("R10 maker code", 6'd0, 16'h8989);
    rd_chk("R10 device code", 6'd1, 16'h1818);
    rd_chk("R10 other index", 6'd2, 16'h0000);
    wr(6'd0, 16'h00FF, 2'b11);

    // R11 query table
    wr(6'd0, 16'h0098, 2'b11);
    rd_chk("R11 Q", 6'h10, 16'h5151);
    rd_chk("R11 R", 6'h11, 16'h5252);
    rd_chk("R11 Y", 6'h12, 16'h5959);
    rd_chk("R11 set", 6'h13, 16'h0101);
    rd_chk("R11 size", 6'h27, 16'h0606);
    rd_chk("R11 regions", 6'h2C, 16'h0101);
    rd_chk("R11 blocks", 6'h2D, 16'h0303);
    rd_chk("R11 unlisted", 6'h05, 16'h0000);
    wr(6'd0, 16'h0000, 2'b11);
    rd_chk("R11 stays in query", 6'h10, 16'h5151);
    wr(6'd0, 16'h00FF, 2'b11);
    rd_chk("R11 exit query", 6'd12, 16'hBEEF);

    // R4 read-only behaviour
    ro_mode = 1'b1;
    wr(6'd0, 16'h0050, 2'b11);
    wr(6'd33, 16'h0020, 2'b11); ref_erase(6'd33);
    wr(6'd33, 16'h00D0, 2'b11);
    rd_chk("R4 erase error bit", 6'd33, 16'hA0A0);
    sweep("R4 erase refused");
    wr(6'd0, 16'h0050, 2'b11);
    prog(6'd12, 16'h1234, 2'b11);
    rd_chk("R4 program error bit", 6'd12, 16'h9090);
    wr(6'd0, 16'h00FF, 2'b11);
    rd_chk("R4 program refused", 6'd12, 16'hBEEF);
    ro_mode = 1'b0;

    // R12 unknown command
    wr(6'd0, 16'h0050, 2'b11);
    prog(6'd1, 16'h0F0F, 2'b11);
    wr(6'd0, 16'h0033, 2'b11);
    chk("R12 seq_err pulse", 16'(seq_err), 16'h1);
    @(negedge clk);
    chk("R12 pulse ends", 16'(seq_err), 16'h0);
    rd_chk("R12 read-array", 6'd1, 16'h0F0F);
    wr(6'd0, 16'h0070, 2'b11);
    rd_chk("R12 status kept", 6'd0, 16'h8080);
    @(negedge clk);
    chk("R13 rd_valid drops", 16'(rd_valid), 16'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule